// File: doc/BRIEF.md
# Path-Associative Trace Cache with Most-Recent Substitution

This block is the trace lookup stage of a wide fetch front end. Each cycle it may receive a fetch address together with the branch directions that a multi-branch predictor guessed for the next few conditional branches. It searches one set of a set-associative store of traces. A trace matches when both its start address and the directions of the branches it holds agree with the request. Several traces that start at the same address but follow different paths may sit side by side in one set.

When the start address is found but none of the stored paths agrees with the prediction, the block treats the prediction as probably wrong. It delivers the most recently used trace for that address and raises a substitution flag, so the front end can override the predictor. If no trace starts at the address, both flags stay low and the fetch falls back to the instruction cache, which lies outside this block. Completed traces arrive from a fill unit through a write port. Recency is kept as per-way age counters in each set, and those counters serve both eviction and the choice of which trace to substitute. The instructions of a trace are carried only as an opaque payload tag.

Top module: `trace_subst_cache`

## Requirements
- R1: After synchronous reset every entry is invalid, so any lookup returns hit=0 and subst=0 with way, payload and next address all zero.
- R2: A lookup at edge k whose address equals a valid entry's start address, and whose path agrees with it, reports hit=1 after edge k. The report carries that entry's way, payload and next fetch address.
- R3: Path comparison covers only the low `count` direction bits of the stored trace (count 0..3, bit 0 is the first branch). Request direction bits at or above the count are ignored.
- R4: If the address matches one or more valid entries in the set but no path agrees, the response has subst=1 and hit=0. It delivers the matching entry with the lowest age, meaning the most recently used.
- R5: If no valid entry in the indexed set has the requested start address, the response has hit=0 and subst=0. The set index is address bits [OFS_W +: log2(SETS)].
- R6: A delivered trace, whether from a hit or a substitution, becomes the most recently used way of its set.
- R7: A fill with no matching entry goes to the lowest-numbered invalid way. If every way is valid, it replaces the least recently used way. The filled way becomes most recently used.
- R8: A fill whose start address, branch count and masked path equal an existing entry overwrites that entry in its own way.
- R9: A cycle with req_valid=0 produces hit=0 and subst=0 on the next response.
- R10: A lookup in the same cycle as a fill sees the contents held before that fill.
- R11: When more than one entry hits, the most recently used one is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_pc | input | PC_W | Fetch address |
| req_path | input | 3 | Predicted directions, bit 0 first branch |
| fill_valid | input | 1 | Write a completed trace |
| fill_pc | input | PC_W | Trace start address |
| fill_path | input | 3 | Trace branch directions |
| fill_cnt | input | 2 | Conditional branches in the trace (0..3) |
| fill_next_pc | input | PC_W | Fetch address after the trace |
| fill_payload | input | PAY_W | Opaque trace tag |
| resp_hit | output | 1 | Path-matching trace delivered |
| resp_subst | output | 1 | Most recent trace substituted for a path miss |
| resp_way | output | log2(WAYS) | Way delivered |
| resp_payload | output | PAY_W | Payload of the delivered trace |
| resp_next_pc | output | PC_W | Next fetch address of the delivered trace |

## Verification
The bench uses the defaults: 16 sets, 4 ways, a 32-bit address, an 8-bit payload and 2 offset bits. At four ways a single set fills within a few fills, so eviction of the oldest way is easy to reach. With 16 sets, addresses 0x1000, 0x2000 and 0x5000 all share set 0 while 0x1004 and 0x1008 fall in other sets. That layout lets one set hold two paths of the same start address next to unrelated traces, which brings substitution order, in-place overwrite and multi-hit recency into a short vector walk.

// File: rtl/tc_pkg.sv
// Shared types for the trace cache: branch path width and masking.
// Assumes at most three conditional branches per trace.
package tc_pkg;
    localparam int BR_MAX = 3;
    localparam int CNT_W  = 2;

    typedef logic [BR_MAX-1:0] path_t;
    typedef logic [CNT_W-1:0]  brcnt_t;

    // Mask selecting the direction bits a trace with c branches really holds.
    function automatic path_t valid_mask(brcnt_t c);
        path_t m;
        for (int i = 0; i < BR_MAX; i++) m[i] = (i < int'(c));
        return m;
    endfunction
endpackage

// File: rtl/tc_way_cmp.sv
// Compares one stored entry against a (start address, path) key.
// Assumes the entry's branch count defines which path bits are meaningful.
module tc_way_cmp
    import tc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            vld,
    input  logic [PC_W-1:0] tag_pc,
    input  path_t           tag_path,
    input  brcnt_t          tag_cnt,
    input  logic [PC_W-1:0] key_pc,
    input  path_t           key_path,
    output logic            pc_eq,
    output logic            path_eq
);
    path_t msk;

    // Address and masked-path comparison for this way.
    always_comb begin
        msk     = valid_mask(tag_cnt);
        pc_eq   = vld && (tag_pc == key_pc);
        path_eq = ((tag_path & msk) == (key_path & msk));
    end
endmodule

// File: rtl/tc_mru_pick.sv
// Among candidate ways, selects the one with the lowest age (most recent).
// Assumes ages within a set form a permutation, so the choice is unique.
module tc_mru_pick #(
    parameter int WAYS = 4,
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             cand,
    input  logic [WAYS-1:0][AGE_W-1:0]  ages,
    output logic                        any,
    output logic [AGE_W-1:0]            sel
);
    logic [AGE_W-1:0] best;

    // Linear scan for the youngest candidate.
    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '1;
        for (int i = 0; i < WAYS; i++) begin
            if (cand[i] && (!any || ages[i] < best)) begin
                any  = 1'b1;
                sel  = AGE_W'(i);
                best = ages[i];
            end
        end
    end

    // The chosen way must be one of the candidates (R4, R11).
    always_comb begin
        if (any) assert_pick_cand_R11: assert (cand[sel]);
    end
endmodule

// File: rtl/tc_lru.sv
// Per-set true LRU state as age counters (0 = most recent). Two touch ports:
// lookup delivery and fill. If both hit the same set, the fill touch is applied last.
// Assumes one reset pulse before use; ages reset to the way index.
module tc_lru #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_en,
    input  logic [IDX_W-1:0]           lk_set,
    input  logic [AGE_W-1:0]           lk_way,
    input  logic                       fl_en,
    input  logic [IDX_W-1:0]           fl_set,
    input  logic [AGE_W-1:0]           fl_way,
    output logic [WAYS-1:0][AGE_W-1:0] ages_lk,
    output logic [WAYS-1:0][AGE_W-1:0] ages_fl
);
    typedef logic [WAYS-1:0][AGE_W-1:0] ageset_t;

    ageset_t age_q [SETS];
    ageset_t age_d [SETS];

    // Make way w youngest; every way younger than it ages by one.
    function automatic ageset_t touch(ageset_t a, logic [AGE_W-1:0] w);
        ageset_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (AGE_W'(i) == w)   r[i] = '0;
            else if (a[i] < a[w]) r[i] = a[i] + 1'b1;
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    // Next-state ages: lookup touch, then fill touch.
    always_comb begin
        age_d = age_q;
        if (lk_en) age_d[lk_set] = touch(age_d[lk_set], lk_way);
        if (fl_en) age_d[fl_set] = touch(age_d[fl_set], fl_way);
    end

    // Age register with synchronous reset to a valid permutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int i = 0; i < WAYS; i++) age_q[s][i] <= AGE_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    assign ages_lk = age_q[lk_set];
    assign ages_fl = age_q[fl_set];

    // A lone lookup touch leaves the touched way youngest (R6).
    assert_mru_touch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !fl_en) |=> (age_q[$past(lk_set)][$past(lk_way)] == '0));

    // A fill touch always leaves the filled way youngest (R7).
    assert_fill_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> (age_q[$past(fl_set)][$past(fl_way)] == '0));

    // Each set keeps exactly one youngest way (R7).
    for (genvar s = 0; s < SETS; s++) begin : g_perm
        logic [WAYS-1:0] zero_m;
        always_comb
            for (int i = 0; i < WAYS; i++) zero_m[i] = (age_q[s][i] == '0);
        assert_one_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(zero_m) == 1);
    end
endmodule

// File: rtl/trace_subst_cache.sv
// Set-associative, path-associative trace cache with most-recent substitution.
// A lookup that finds the start address but not the predicted path delivers
// the youngest trace for that address and flags it. Responses are registered
// one cycle after the request. Lookups read the contents before a same-cycle fill.
module trace_subst_cache
    import tc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int PAY_W = 8,
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int OFS_W = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PC_W-1:0]  req_pc,
    input  logic [2:0]       req_path,
    input  logic             fill_valid,
    input  logic [PC_W-1:0]  fill_pc,
    input  logic [2:0]       fill_path,
    input  logic [1:0]       fill_cnt,
    input  logic [PC_W-1:0]  fill_next_pc,
    input  logic [PAY_W-1:0] fill_payload,
    output logic             resp_hit,
    output logic             resp_subst,
    output logic [WAY_W-1:0] resp_way,
    output logic [PAY_W-1:0] resp_payload,
    output logic [PC_W-1:0]  resp_next_pc
);
    // Entry storage, indexed [set][way].
    logic             ent_vld  [SETS][WAYS];
    logic [PC_W-1:0]  ent_pc   [SETS][WAYS];
    path_t            ent_path [SETS][WAYS];
    brcnt_t           ent_cnt  [SETS][WAYS];
    logic [PC_W-1:0]  ent_nxt  [SETS][WAYS];
    logic [PAY_W-1:0] ent_pay  [SETS][WAYS];

    logic [IDX_W-1:0] lk_set, fl_set;
    logic [WAYS-1:0]  lk_pc_c, lk_hit_c, fl_same_c;
    logic [WAYS-1:0]  lk_pc_eq, lk_path_eq, fl_pc_eq, fl_path_eq;
    logic [WAYS-1:0][WAY_W-1:0] ages_lk, ages_fl;
    logic             hit_any, pc_any, deliver;
    logic [WAY_W-1:0] hit_way, pc_way, del_way, fl_way;

    assign lk_set = req_pc[OFS_W +: IDX_W];
    assign fl_set = fill_pc[OFS_W +: IDX_W];

    // One lookup comparator and one fill comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tc_way_cmp #(.PC_W(PC_W)) i_lk_cmp (
            .vld(ent_vld[lk_set][w]), .tag_pc(ent_pc[lk_set][w]),
            .tag_path(ent_path[lk_set][w]), .tag_cnt(ent_cnt[lk_set][w]),
            .key_pc(req_pc), .key_path(req_path),
            .pc_eq(lk_pc_eq[w]), .path_eq(lk_path_eq[w]));
        tc_way_cmp #(.PC_W(PC_W)) i_fl_cmp (
            .vld(ent_vld[fl_set][w]), .tag_pc(ent_pc[fl_set][w]),
            .tag_path(ent_path[fl_set][w]), .tag_cnt(ent_cnt[fl_set][w]),
            .key_pc(fill_pc), .key_path(fill_path),
            .pc_eq(fl_pc_eq[w]), .path_eq(fl_path_eq[w]));
        assign lk_pc_c[w]   = lk_pc_eq[w];
        assign lk_hit_c[w]  = lk_pc_eq[w] && lk_path_eq[w];
        assign fl_same_c[w] = fl_pc_eq[w] && fl_path_eq[w]
                              && (ent_cnt[fl_set][w] == fill_cnt);
    end

    tc_mru_pick #(.WAYS(WAYS)) i_pick_hit (
        .cand(lk_hit_c), .ages(ages_lk), .any(hit_any), .sel(hit_way));
    tc_mru_pick #(.WAYS(WAYS)) i_pick_pc (
        .cand(lk_pc_c), .ages(ages_lk), .any(pc_any), .sel(pc_way));

    assign deliver = req_valid && pc_any;
    assign del_way = hit_any ? hit_way : pc_way;

    // Fill way: matching entry, else lowest invalid way, else oldest way.
    always_comb begin
        logic found;
        found  = 1'b0;
        fl_way = '0;
        for (int i = 0; i < WAYS; i++)
            if (!found && fl_same_c[i]) begin found = 1'b1; fl_way = WAY_W'(i); end
        for (int i = 0; i < WAYS; i++)
            if (!found && !ent_vld[fl_set][i]) begin found = 1'b1; fl_way = WAY_W'(i); end
        for (int i = 0; i < WAYS; i++)
            if (!found && ages_fl[i] == WAY_W'(WAYS-1)) begin found = 1'b1; fl_way = WAY_W'(i); end
    end

    tc_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
        .clk(clk), .rst_n(rst_n),
        .lk_en(deliver), .lk_set(lk_set), .lk_way(del_way),
        .fl_en(fill_valid), .fl_set(fl_set), .fl_way(fl_way),
        .ages_lk(ages_lk), .ages_fl(ages_fl));

    // Entry write from the fill unit; reset clears valid bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int i = 0; i < WAYS; i++) ent_vld[s][i] <= 1'b0;
        end else if (fill_valid) begin
            ent_vld [fl_set][fl_way] <= 1'b1;
            ent_pc  [fl_set][fl_way] <= fill_pc;
            ent_path[fl_set][fl_way] <= fill_path;
            ent_cnt [fl_set][fl_way] <= fill_cnt;
            ent_nxt [fl_set][fl_way] <= fill_next_pc;
            ent_pay [fl_set][fl_way] <= fill_payload;
        end
    end

    // Registered response, zero when nothing is delivered.
    always_ff @(posedge clk) begin
        if (!rst_n || !deliver) begin
            resp_hit     <= 1'b0;
            resp_subst   <= 1'b0;
            resp_way     <= '0;
            resp_payload <= '0;
            resp_next_pc <= '0;
        end else begin
            resp_hit     <= hit_any;
            resp_subst   <= !hit_any;
            resp_way     <= del_way;
            resp_payload <= ent_pay[lk_set][del_way];
            resp_next_pc <= ent_nxt[lk_set][del_way];
        end
    end

    // Hit and substitution never coincide (R4).
    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_hit && resp_subst));

    // No request gives no delivery (R9).
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(resp_hit || resp_subst));

    // No address match in the set gives neither flag (R5).
    assert_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_pc_c == '0) |=> !(resp_hit || resp_subst));
endmodule

// File: tb/test_trace_subst_cache.sv
module test_trace_subst_cache;
    localparam int PC_W = 32, PAY_W = 8, WAY_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [PC_W-1:0]  req_pc = '0, fill_pc = '0, fill_next_pc = '0;
    logic [2:0]       req_path = '0, fill_path = '0;
    logic [1:0]       fill_cnt = '0;
    logic [PAY_W-1:0] fill_payload = '0;
    logic             resp_hit, resp_subst;
    logic [WAY_W-1:0] resp_way;
    logic [PAY_W-1:0] resp_payload;
    logic [PC_W-1:0]  resp_next_pc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_subst_cache i_trace_subst_cache (
        .clk, .rst_n, .req_valid, .req_pc, .req_path, .fill_valid, .fill_pc,
        .fill_path, .fill_cnt, .fill_next_pc, .fill_payload, .resp_hit,
        .resp_subst, .resp_way, .resp_payload, .resp_next_pc);

    typedef struct packed {
        logic        is_fill;
        logic [31:0] pc;
        logic [2:0]  path;
        logic [1:0]  cnt;
        logic [7:0]  pay;
        logic        eh, es;
        logic [1:0]  ew;
        logic [7:0]  ep;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h1000, 3'b001, 2'd2, 8'h11, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7 invalid way 0
        '{1'b0, 32'h1000, 3'b101, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h11, 4'd3 },  // R3 bit 2 ignored
        '{1'b1, 32'h1000, 3'b010, 2'd2, 8'h22, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7 way 1
        '{1'b1, 32'h2000, 3'b000, 2'd0, 8'h33, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7 way 2
        '{1'b0, 32'h1000, 3'b011, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h22, 4'd4 },  // R4 youngest of w0,w1
        '{1'b0, 32'h1000, 3'b000, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h22, 4'd4 },  // R4
        '{1'b0, 32'h1000, 3'b001, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h11, 4'd2 },  // R2
        '{1'b0, 32'h1000, 3'b111, 2'd0, 8'h00, 1'b0, 1'b1, 2'd0, 8'h11, 4'd6 },  // R6 w0 now youngest
        '{1'b0, 32'h1004, 3'b000, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 4'd5 },  // R5 empty set
        '{1'b0, 32'h3000, 3'b000, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 4'd5 },  // R5 other tag
        '{1'b0, 32'h2000, 3'b111, 2'd0, 8'h00, 1'b1, 1'b0, 2'd2, 8'h33, 4'd3 },  // R3 count 0
        '{1'b1, 32'h1000, 3'b001, 2'd2, 8'h44, 1'b0, 1'b0, 2'd0, 8'h00, 4'd8 },  // R8 overwrite
        '{1'b0, 32'h1000, 3'b001, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h44, 4'd8 },  // R8
        '{1'b1, 32'h4000, 3'b000, 2'd1, 8'h55, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7 way 3
        '{1'b1, 32'h5000, 3'b000, 2'd0, 8'h66, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7 evicts w1
        '{1'b0, 32'h5000, 3'b000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd1, 8'h66, 4'd7 },  // R7
        '{1'b0, 32'h1000, 3'b010, 2'd0, 8'h00, 1'b0, 1'b1, 2'd0, 8'h44, 4'd7 },  // R7 old path gone
        '{1'b1, 32'h1008, 3'b000, 2'd1, 8'h77, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7
        '{1'b1, 32'h1008, 3'b000, 2'd2, 8'h88, 1'b0, 1'b0, 2'd0, 8'h00, 4'd7 },  // R7
        '{1'b0, 32'h1008, 3'b000, 2'd0, 8'h00, 1'b1, 1'b0, 2'd1, 8'h88, 4'd11}   // R11 two hits
    };

    task automatic check(input logic eh, es, input logic [1:0] ew,
                         input logic [7:0] ep, input int rq);
        logic [31:0] en;
        en = (eh || es) ? 32'h8000 + 32'(ep) : 32'h0;
        n_chk++;
        if (resp_hit !== eh || resp_subst !== es || resp_way !== ew ||
            resp_payload !== ep || resp_next_pc !== en) begin
            n_fail++;
            $display("FAIL R%0d: got hit=%b subst=%b way=%0d pay=%h nxt=%h, expected hit=%b subst=%b way=%0d pay=%h nxt=%h",
                     rq, resp_hit, resp_subst, resp_way, resp_payload, resp_next_pc,
                     eh, es, ew, ep, en);
        end
    endtask

    task automatic drive_fill(input logic [31:0] pc, input logic [2:0] p,
                              input logic [1:0] c, input logic [7:0] pay);
        fill_valid = 1'b1; fill_pc = pc; fill_path = p; fill_cnt = c;
        fill_payload = pay; fill_next_pc = 32'h8000 + 32'(pay);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: empty after reset
        @(negedge clk) begin req_valid = 1'b1; req_pc = 32'h1000; req_path = 3'b001; end
        @(posedge clk); #1 check(1'b0, 1'b0, 2'd0, 8'h00, 1);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            req_valid = 1'b0; fill_valid = 1'b0;
            if (VECS[v].is_fill)
                drive_fill(VECS[v].pc, VECS[v].path, VECS[v].cnt, VECS[v].pay);
            else begin
                req_valid = 1'b1; req_pc = VECS[v].pc; req_path = VECS[v].path;
            end
            @(posedge clk); #1;
            if (!VECS[v].is_fill)
                check(VECS[v].eh, VECS[v].es, VECS[v].ew, VECS[v].ep, int'(VECS[v].rq));
        end

        // R9: idle cycle after a hit
        @(negedge clk) begin fill_valid = 1'b0; req_valid = 1'b0; end
        @(posedge clk); #1 check(1'b0, 1'b0, 2'd0, 8'h00, 9);

        // R10: same-cycle fill and lookup in set 3 sees old contents
        @(negedge clk) begin
            drive_fill(32'h100C, 3'b000, 2'd0, 8'h99);
            req_valid = 1'b1; req_pc = 32'h100C; req_path = 3'b000;
        end
        @(posedge clk); #1 check(1'b0, 1'b0, 2'd0, 8'h00, 10);
        @(negedge clk) fill_valid = 1'b0;
        @(posedge clk); #1 check(1'b1, 1'b0, 2'd0, 8'h99, 10);

        // R1: reset again empties the cache
        @(negedge clk) begin rst_n = 1'b0; req_valid = 1'b0; end
        @(posedge clk);
        @(negedge clk) begin rst_n = 1'b1; req_valid = 1'b1; req_pc = 32'h100C; end
        @(posedge clk); #1 check(1'b0, 1'b0, 2'd0, 8'h00, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule